// File: doc/BRIEF.md
# Transition-to-Return-to-Zero Bridge Sequencer

This block sequences a word-wide crossing from a non-return-to-zero, level-encoded two-phase channel into a return-to-zero dual-rail function block, and back out to a second level-encoded two-phase channel. Every bit on the two-phase side travels on two wires, a value wire and a parity wire. The XOR of the two gives the bit's phase. A word is present once every bit shows the phase the block expects next.

When a complete word has arrived, the function block is idle and the previous result has been acknowledged downstream, the sequencer raises the function enable. It drives the word as dual-rail pairs. It then waits for the function block's completion with a valid dual-rail result. The result is converted to level-encoded form with the opposite output phase. In the same cycle the enable and the dual-rail drive fall and the left acknowledge toggles. The sender may therefore present the next word while the function block is still returning to zero. A new evaluation starts only after the function block's completion has dropped.

This is a cycle-based synchronous model. All handshakes are single bits, and all outputs come from registers.

Top module: `nrz_rz_bridge_ctrl`

## Requirements
- R1: During and right after a synchronous reset, ack_left, fx_en, fx_t, fx_f, rt_data and rt_par are all zero. The expected input phase is odd (1) and the output phase is even (0).
- R2: A word is taken only when, for every bit i, lt_data[i] XOR lt_par[i] equals the expected input phase. While only some bits have switched, fx_en stays low.
- R3: On acceptance, fx_en goes high one clock after the complete word is seen. Each bit then drives fx_t[i] = lt_data[i] and fx_f[i] = NOT lt_data[i].
- R4: fx_en does not rise while fx_done is high, or while ack_right differs from the current output phase (previous result not yet acknowledged).
- R5: When fx_done is high and every result pair has exactly one rail high, the next clock edge does three things. It sets rt_data = fx_rt and rt_par = fx_rt XOR the new output phase. It drops fx_en. It clears fx_t and fx_f.
- R6: ack_left toggles exactly once per word, on the edge where fx_en falls, which is before the function block has returned to zero.
- R7: After fx_en falls, no new evaluation starts until fx_done has been seen low, even if the next word is already present.
- R8: rt_data and rt_par hold their values except on the edge that produces a new result.
- R9: Every bit of an output word carries the same phase (rt_data XOR rt_par uniform), and successive output words alternate phase, starting with odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_data | input | IN_W | Left channel value wires |
| lt_par | input | IN_W | Left channel parity wires |
| ack_left | output | 1 | Two-phase acknowledge to the sender |
| fx_en | output | 1 | Function enable (high: evaluate, low: return to zero) |
| fx_t | output | IN_W | Dual-rail true rails to the function block |
| fx_f | output | IN_W | Dual-rail false rails to the function block |
| fx_rt | input | OUT_W | Function result true rails |
| fx_rf | input | OUT_W | Function result false rails |
| fx_done | input | 1 | Function completion (high: result valid, low: reset finished) |
| rt_data | output | OUT_W | Right channel value wires |
| rt_par | output | OUT_W | Right channel parity wires |
| ack_right | input | 1 | Two-phase acknowledge from the receiver |

## Verification
Words are delivered in four ways, each separating a different fault:
- All bits switching together checks the basic path and the phase alternation.
- Bits switching one at a time with long gaps separates a per-bit check from a whole-word check.
- A held right acknowledge shows whether evaluation is wrongly allowed to overrun an unconsumed result.
- A function stub that keeps completion high long after the enable falls shows whether the left acknowledge comes early, as required, and whether the next evaluation waits for the return to zero.

A long stream with varied stub latency and receiver delay is checked against a queue of expected results on every clock.

// File: rtl/nrz_rz_pkg.sv
package nrz_rz_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_EVAL = 2'd1,
    SEQ_RTZ  = 2'd2
  } seq_t;

  function automatic logic lets_phase(input logic v, input logic p);
    return v ^ p;
  endfunction
endpackage

// File: rtl/lets_word_detect.sv
module lets_word_detect #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] vals,
  input  logic [W-1:0] pars,
  input  logic         want_ph,
  output logic         full
);
  import nrz_rz_pkg::*;
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = (lets_phase(vals[i], pars[i]) == want_ph);
  end

  assign full = &bit_ok;
endmodule

// File: rtl/dr_word_valid.sv
module dr_word_valid #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] t_rail,
  input  logic [W-1:0] f_rail,
  output logic         valid
);
  logic [W-1:0] pair_ok;

  for (genvar i = 0; i < W; i++) begin : g_pair
    assign pair_ok[i] = t_rail[i] ^ f_rail[i];
  end

  assign valid = &pair_ok;
endmodule

// File: rtl/lets_out_enc.sv
module lets_out_enc #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] vals,
  input  logic         ph,
  output logic [W-1:0] pars
);
  for (genvar i = 0; i < W; i++) begin : g_enc
    assign pars[i] = vals[i] ^ ph;
  end
endmodule

// File: rtl/nrz_rz_bridge_ctrl.sv
module nrz_rz_bridge_ctrl #(
  parameter int unsigned IN_W  = 4,
  parameter int unsigned OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  lt_data,
  input  logic [IN_W-1:0]  lt_par,
  output logic             ack_left,
  output logic             fx_en,
  output logic [IN_W-1:0]  fx_t,
  output logic [IN_W-1:0]  fx_f,
  input  logic [OUT_W-1:0] fx_rt,
  input  logic [OUT_W-1:0] fx_rf,
  input  logic             fx_done,
  output logic [OUT_W-1:0] rt_data,
  output logic [OUT_W-1:0] rt_par,
  input  logic             ack_right
);
  import nrz_rz_pkg::*;

  localparam logic [IN_W-1:0]  IN_ZERO  = '0;
  localparam logic [IN_W-1:0]  IN_ONES  = '1;
  localparam logic [OUT_W-1:0] OUT_ZERO = '0;
  localparam logic [OUT_W-1:0] OUT_ONES = '1;

  seq_t             st;
  logic             in_ph;
  logic             out_ph;
  logic             word_full;
  logic             res_valid;
  logic [OUT_W-1:0] next_par;
  logic             slot_free;

  lets_word_detect #(.W(IN_W)) u_in_cd (
    .vals    (lt_data),
    .pars    (lt_par),
    .want_ph (in_ph),
    .full    (word_full)
  );

  dr_word_valid #(.W(OUT_W)) u_res_cd (
    .t_rail (fx_rt),
    .f_rail (fx_rf),
    .valid  (res_valid)
  );

  lets_out_enc #(.W(OUT_W)) u_enc (
    .vals (fx_rt),
    .ph   (~out_ph),
    .pars (next_par)
  );

  assign slot_free = (ack_right == out_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEQ_IDLE;
      in_ph    <= 1'b1;
      out_ph   <= 1'b0;
      ack_left <= 1'b0;
      fx_en    <= 1'b0;
      fx_t     <= IN_ZERO;
      fx_f     <= IN_ZERO;
      rt_data  <= OUT_ZERO;
      rt_par   <= OUT_ZERO;
    end else begin
      case (st)
        SEQ_IDLE: begin
          if (word_full && !fx_done && slot_free) begin
            fx_en <= 1'b1;
            fx_t  <= lt_data;
            fx_f  <= ~lt_data;
            st    <= SEQ_EVAL;
          end
        end
        SEQ_EVAL: begin
          if (fx_done && res_valid) begin
            rt_data  <= fx_rt;
            rt_par   <= next_par;
            out_ph   <= ~out_ph;
            fx_en    <= 1'b0;
            fx_t     <= IN_ZERO;
            fx_f     <= IN_ZERO;
            ack_left <= ~ack_left;
            in_ph    <= ~in_ph;
            st       <= SEQ_RTZ;
          end
        end
        SEQ_RTZ: begin
          if (!fx_done) st <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // R2: evaluation starts only on a complete word of the expected phase
  a_r2_word_complete: assert property (@(posedge clk) disable iff (rst)
    $rose(fx_en) |-> $past(word_full));

  // R3: dual-rail drive is complementary when evaluation starts
  a_r3_rails_complement: assert property (@(posedge clk) disable iff (rst)
    $rose(fx_en) |-> ((fx_t ^ fx_f) == IN_ONES));

  // R4: no evaluation while the block is busy or the output slot is full
  a_r4_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(fx_en) |-> (!$past(fx_done) &&
                      ($past(ack_right) == $past(rt_data[0] ^ rt_par[0]))));

  // R5: the enable falls together with a new output phase
  a_r5_output_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(fx_en) |-> ((rt_data[0] ^ rt_par[0]) != $past(rt_data[0] ^ rt_par[0])));

  // R5: dual-rail drive is all zero outside evaluation
  a_r5_rails_rtz: assert property (@(posedge clk) disable iff (rst)
    !fx_en |-> (fx_t == IN_ZERO && fx_f == IN_ZERO));

  // R6: the left acknowledge toggles on the falling enable
  a_r6_ack_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(fx_en) |-> (ack_left != $past(ack_left)));

  // R6: the left acknowledge toggles on no other edge
  a_r6_ack_only_fall: assert property (@(posedge clk) disable iff (rst)
    (ack_left != $past(ack_left)) |-> $fell(fx_en));

  // R8: the output holds unless a result is produced
  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    !$fell(fx_en) |-> ($stable(rt_data) && $stable(rt_par)));

  // R9: every output bit carries the same phase
  a_r9_uniform_phase: assert property (@(posedge clk) disable iff (rst)
    (((rt_data ^ rt_par) == OUT_ZERO) || ((rt_data ^ rt_par) == OUT_ONES)));
endmodule

// File: tb/sim_nrz_rz_bridge_ctrl.sv
module sim_nrz_rz_bridge_ctrl;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] lt_data = '0, lt_par = '0;
  logic ack_left, fx_en;
  logic [W-1:0] fx_t, fx_f;
  logic [W-1:0] fx_rt, fx_rf;
  logic fx_done;
  logic [W-1:0] rt_data, rt_par;
  logic ack_right = 1'b0;

  int checks = 0, fails = 0;
  int stub_lat = 2, stub_rlat = 2, scnt = 0;
  int sent = 0, acks = 0, outs = 0;
  bit auto_ack = 1'b1;
  int rdel = 0, rcnt = 0;
  logic in_ph = 1'b0;
  logic [W-1:0] cur_word = '0;
  logic [W-1:0] expq[$];
  logic last_oph = 1'b0, last_lack = 1'b0, last_en = 1'b0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  nrz_rz_bridge_ctrl #(.IN_W(W), .OUT_W(W)) u0 (
    .clk(clk), .rst(rst), .lt_data(lt_data), .lt_par(lt_par),
    .ack_left(ack_left), .fx_en(fx_en), .fx_t(fx_t), .fx_f(fx_f),
    .fx_rt(fx_rt), .fx_rf(fx_rf), .fx_done(fx_done),
    .rt_data(rt_data), .rt_par(rt_par), .ack_right(ack_right));

  function automatic logic [W-1:0] fn(input logic [W-1:0] x);
    return ~(x + W'(3));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Function block stub: four-phase evaluate then return to zero
  always @(posedge clk) begin
    if (rst) begin
      fx_rt <= '0; fx_rf <= '0; fx_done <= 1'b0; scnt = 0;
    end else if (fx_en && !fx_done && ((fx_t ^ fx_f) == '1)) begin
      scnt = scnt + 1;
      if (scnt >= stub_lat) begin
        fx_rt <= fn(fx_t); fx_rf <= ~fn(fx_t); fx_done <= 1'b1; scnt = 0;
      end
    end else if (!fx_en && fx_done) begin
      scnt = scnt + 1;
      if (scnt >= stub_rlat) begin
        fx_rt <= '0; fx_rf <= '0; fx_done <= 1'b0; scnt = 0;
      end
    end else scnt = 0;
  end

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      logic [W-1:0] ov;
      ov = rt_data ^ rt_par;
      if (ov[0] != last_oph) begin
        logic [W-1:0] e;
        outs++;
        check((ov == '0) || (ov == '1), "R9 uniform phase", ov, {W{ov[0]}});
        check(ov[0] == ~last_oph, "R9 alternation", ov[0], ~last_oph);
        if (expq.size() == 0) begin
          check(1'b0, "R5 unexpected output", rt_data, 0);
        end else begin
          e = expq.pop_front();
          check(rt_data == e, "R5 output value", rt_data, e);
        end
        check(!fx_en && last_en, "R5 enable falls with output", fx_en, 0);
        last_oph = ov[0];
      end else if ((ov != '0) && (ov != '1)) begin
        check(1'b0, "R9 mixed phase", ov, {W{last_oph}});
      end
      if (ack_left != last_lack) begin
        acks++;
        check(last_en && !fx_en, "R6 ack with enable fall", fx_en, 0);
        last_lack = ack_left;
      end
      if (fx_en && !last_en) begin
        check(fx_t == cur_word && fx_f == ~cur_word, "R3 dual-rail drive", fx_t, cur_word);
      end
      last_en = fx_en;
      if (auto_ack && ack_right != last_oph) begin
        if (rcnt >= rdel) begin ack_right = last_oph; rcnt = 0; end
        else rcnt++;
      end
    end
  end

  task automatic put_word(input logic [W-1:0] v, input bit skew);
    logic ph;
    ph = ~in_ph;
    cur_word = v;
    expq.push_back(fn(v));
    if (skew) begin
      for (int i = 0; i < W; i++) begin
        lt_data[i] = v[i]; lt_par[i] = v[i] ^ ph;
        repeat (2) @(negedge clk);
      end
    end else begin
      lt_data = v; lt_par = v ^ {W{ph}};
    end
    in_ph = ph;
    sent++;
  endtask

  task automatic wait_ack();
    int n;
    n = 0;
    while (acks != sent && n < 2000) begin @(negedge clk); n++; end
    check(acks == sent, "R6 word acknowledged", acks, sent);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    done_flag = 1'b1;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    logic ph;
    logic [W-1:0] v;
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held and after release
    check(ack_left == 0 && fx_en == 0, "R1 reset handshake", {ack_left, fx_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(fx_t == 0 && fx_f == 0, "R1 reset rails", {fx_t, fx_f}, 0);
    check(rt_data == 0 && rt_par == 0, "R1 reset output", {rt_data, rt_par}, 0);
    check(ack_left == 0 && fx_en == 0, "R1 idle after reset", {ack_left, fx_en}, 0);

    // R2: partial word is not accepted
    stub_lat = 3;
    v = 4'h5; ph = ~in_ph; cur_word = v; expq.push_back(fn(v));
    for (int i = 0; i < W - 1; i++) begin
      lt_data[i] = v[i]; lt_par[i] = v[i] ^ ph;
      repeat (3) @(negedge clk);
    end
    check(fx_en == 0, "R2 partial word ignored", fx_en, 0);
    lt_data[W-1] = v[W-1]; lt_par[W-1] = v[W-1] ^ ph;
    in_ph = ph; sent++;
    @(negedge clk);
    check(fx_en == 1, "R3 enable one clock after word", fx_en, 1);
    check(fx_t == v && fx_f == ~v, "R3 rails carry word", fx_t, v);
    check(ack_left == 0, "R6 no ack during evaluate", ack_left, 0);
    wait_ack();

    // R4 and R8: held right acknowledge blocks the next evaluation
    repeat (4) @(negedge clk);
    auto_ack = 1'b0;
    put_word(4'hC, 1'b0);
    wait_ack();
    put_word(4'h9, 1'b0);
    repeat (10) @(negedge clk);
    check(fx_en == 0, "R4 blocked by pending right ack", fx_en, 0);
    check(rt_data == fn(4'hC), "R8 output held", rt_data, fn(4'hC));
    ack_right = last_oph;
    @(negedge clk);
    check(fx_en == 1, "R4 starts after right ack", fx_en, 1);
    auto_ack = 1'b1;
    wait_ack();

    // R6 and R7: acknowledge during a slow return to zero
    repeat (6) @(negedge clk);
    stub_rlat = 15;
    put_word(4'h3, 1'b0);
    wait_ack();
    check(fx_done == 1 && fx_en == 0, "R6 ack before return to zero", fx_done, 1);
    put_word(4'hA, 1'b0);
    repeat (5) @(negedge clk);
    check(fx_en == 0, "R7 waits for done low", fx_en, 0);
    n = 0;
    while (fx_done && n < 100) begin @(negedge clk); n++; end
    check(fx_en == 0, "R7 no start on done fall edge", fx_en, 0);
    n = 0;
    while (!fx_en && n < 4) begin @(negedge clk); n++; end
    check(fx_en == 1, "R7 starts after return to zero", fx_en, 1);
    stub_rlat = 2;
    wait_ack();

    // Stream with varied latencies and skewed arrival
    for (int k = 0; k < 24; k++) begin
      stub_lat = 1 + (k % 4);
      stub_rlat = 1 + ((k * 3) % 5);
      rdel = (k * 7) % 4;
      put_word(W'(k * 5 + 1), (k % 5) == 2);
      wait_ack();
    end
    n = 0;
    while (expq.size() != 0 && n < 200) begin @(negedge clk); n++; end
    check(expq.size() == 0, "R5 all results delivered", expq.size(), 0);
    check(outs == sent, "R9 one output per word", outs, sent);

    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule